// File: doc/BRIEF.md
# Priority Microcode Task Switcher

This block picks which hardware task owns a shared microengine. Sixteen tasks take turns on one microsequencer. The block keeps exactly one saved micro address per task, and every microinstruction supplies the address of its successor. Devices raise wakeup requests on a 16-bit vector. Task 0 is the background emulator and always counts as requesting.

A task gives up the engine only when its current microword asserts the yield strobe. On that cycle the block looks at the request vector and picks the highest-numbered requester. If the winner is another task, the block stores the yielding task's next address in that task's slot, makes the winner current and fetches from the winner's stored address. If the winner is the running task, execution simply continues at its next address. When the strobe is low, the fetch address always follows the microword's next-address field. Each microinstruction takes one clock.

Top module: `utask_switcher`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `cur_task` is 0 and `fetch_addr` is 0. Reset sets each task's saved address to that task's number.
- R2: In any cycle where `task_strobe` is 0, the next cycle has the same `cur_task`, and `fetch_addr` equals that cycle's `next_addr`. `wake_req` is ignored in such a cycle.
- R3: In a cycle where `task_strobe` is 1, the next `cur_task` is the highest index `i` for which bit `i` of (`wake_req` OR 1) is set. Bit `i` of `wake_req` is task `i`'s request, and task 15 has the highest priority.
- R4: When a strobe moves execution to a different task, the next `fetch_addr` is that task's saved address. A task entered for the first time after reset starts at its own task number.
- R5: When a strobe moves execution away from the running task, that cycle's `next_addr` is saved for the task. The task resumes from that address on its next entry.
- R6: A strobe with `wake_req` all zero selects task 0.
- R7: A strobe whose winner is the running task leaves `cur_task` unchanged and sets `fetch_addr` to that cycle's `next_addr`.
- R8: The full 10-bit address range, up to 1023, passes through to `fetch_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_req | input | 16 | Per-task wakeup requests; bit i is task i |
| task_strobe | input | 1 | Yield function of the executing microword |
| next_addr | input | 10 | Next-address field of the executing microword |
| cur_task | output | 4 | Task that owns the current microcycle |
| fetch_addr | output | 10 | Address of the microword executing this cycle |

## Verification
A corrupted saved-address slot stays hidden until its task is chosen again. It then appears as a wrong `fetch_addr` in the cycle right after that strobe, which may be many cycles after the corruption. For this reason the stimulus leaves tasks and comes back to them, so that both the saved value and the reset value reach the ports. A wrong current-task register, or a wrong winner, shows in `cur_task` one cycle after the strobe. A wrong self-yield decision shows in the same cycle as a jump to a stale address instead of to `next_addr`.

// File: rtl/utask_pkg.sv
package utask_pkg;
   localparam int unsigned UT_TASKS  = 16;
   localparam int unsigned UT_ADDR_W = 10;
   localparam int unsigned UT_TID_W  = $clog2(UT_TASKS);
   typedef logic [UT_TID_W-1:0]  tid_t;
   typedef logic [UT_ADDR_W-1:0] uaddr_t;
endpackage

// File: rtl/utask_prio_enc.sv
module utask_prio_enc #(
   parameter int unsigned N   = 16,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/utask_mpc_file.sv
module utask_mpc_file #(
   parameter int unsigned N      = 16,
   parameter int unsigned ADDR_W = 10,
   localparam int unsigned IW    = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IW-1:0]     waddr,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [IW-1:0]     raddr,
   output logic [ADDR_W-1:0] rdata
);
   logic [ADDR_W-1:0] slot [N];

   for (genvar g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                      slot[g] <= ADDR_W'(g);
         else if (we && waddr == IW'(g)) slot[g] <= wdata;
      end
   end

   assign rdata = slot[raddr];
endmodule

// File: rtl/utask_switcher.sv
module utask_switcher #(
   parameter int unsigned NUM_TASKS = 16,
   parameter int unsigned ADDR_W    = 10,
   localparam int unsigned TID_W    = $clog2(NUM_TASKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       wake_req,
   input  logic              task_strobe,
   input  logic [ADDR_W-1:0] next_addr,
   output logic [TID_W-1:0]  cur_task,
   output logic [ADDR_W-1:0] fetch_addr
);
   if (NUM_TASKS != 16) begin : g_bad_tasks
      $error("utask_switcher: request vector is 16 bits wide");
   end
   if ((2 ** ADDR_W) < NUM_TASKS) begin : g_bad_addr
      $error("utask_switcher: address space too small for reset vectors");
   end

   logic [TID_W-1:0]  cur_q;
   logic [ADDR_W-1:0] pc_q;
   logic [NUM_TASKS-1:0] eligible;
   logic [TID_W-1:0]  winner;
   logic [ADDR_W-1:0] resume_addr;
   logic              do_switch;

   // Task 0 is always eligible.
   assign eligible  = wake_req | NUM_TASKS'(1);
   assign do_switch = task_strobe && (winner != cur_q);

   utask_prio_enc #(.N(NUM_TASKS)) u_enc (
      .req (eligible),
      .idx (winner)
   );

   utask_mpc_file #(.N(NUM_TASKS), .ADDR_W(ADDR_W)) u_mpc (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (do_switch),
      .waddr (cur_q),
      .wdata (next_addr),
      .raddr (winner),
      .rdata (resume_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         pc_q  <= '0;
      end else if (do_switch) begin
         cur_q <= winner;
         pc_q  <= resume_addr;
      end else begin
         pc_q  <= next_addr;
      end
   end

   assign cur_task   = cur_q;
   assign fetch_addr = pc_q;
endmodule

// File: rtl/utask_switcher_chk.sv
module utask_switcher_chk #(
   parameter int unsigned NUM_TASKS = 16,
   parameter int unsigned ADDR_W    = 10,
   localparam int unsigned TID_W    = $clog2(NUM_TASKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       wake_req,
   input logic              task_strobe,
   input logic [ADDR_W-1:0] next_addr,
   input logic [TID_W-1:0]  cur_task,
   input logic [ADDR_W-1:0] fetch_addr
);
   logic [15:0] elig;
   assign elig = wake_req | 16'd1;

   a_r2_hold_task: assert property (@(posedge clk) disable iff (!rst_n)
      !task_strobe |=> cur_task == $past(cur_task));

   a_r2_follow_next: assert property (@(posedge clk) disable iff (!rst_n)
      !task_strobe |=> fetch_addr == $past(next_addr));

   // R3: after a strobe, the new task is requesting and no higher task was
   a_r3_top_priority: assert property (@(posedge clk) disable iff (!rst_n)
      task_strobe |=> (($past(elig) >> cur_task) == 16'd1));

   a_r7_self_continue: assert property (@(posedge clk) disable iff (!rst_n)
      (task_strobe && ((elig >> cur_task) == 16'd1))
      |=> (fetch_addr == $past(next_addr)) && $stable(cur_task));

   a_r6_idle_task0: assert property (@(posedge clk) disable iff (!rst_n)
      (task_strobe && wake_req == 16'd0) |=> cur_task == '0);
endmodule

bind utask_switcher utask_switcher_chk #(.NUM_TASKS(NUM_TASKS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .task_strobe(task_strobe),
   .next_addr(next_addr), .cur_task(cur_task), .fetch_addr(fetch_addr)
);

// File: tb/tb_utask_switcher.sv
module tb_utask_switcher;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] wake_req = '0;
   logic        task_strobe = 1'b0;
   logic [9:0]  next_addr = '0;
   logic [3:0]  cur_task;
   logic [9:0]  fetch_addr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   utask_switcher dut (
      .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .task_strobe(task_strobe),
      .next_addr(next_addr), .cur_task(cur_task), .fetch_addr(fetch_addr)
   );

   always #5 clk = ~clk;

   // {strobe, req[15:0], next[9:0], exp_task[3:0], exp_addr[9:0]}
   localparam int NV = 13;
   localparam logic [40:0] VEC [NV] = '{
      {1'b0, 16'h0000, 10'd5,    4'd0,  10'd5   }, // R2
      {1'b1, 16'h0010, 10'd7,    4'd4,  10'd4   }, // R3 R4 first entry
      {1'b0, 16'hFFFF, 10'd20,   4'd4,  10'd20  }, // R2 reqs ignored
      {1'b1, 16'h8010, 10'd21,   4'd15, 10'd15  }, // R3
      {1'b1, 16'h8000, 10'd30,   4'd15, 10'd30  }, // R7
      {1'b1, 16'h0000, 10'd31,   4'd0,  10'd7   }, // R6 R5
      {1'b1, 16'h0011, 10'd8,    4'd4,  10'd21  }, // R5
      {1'b1, 16'h00F0, 10'd22,   4'd7,  10'd7   }, // R3 R4
      {1'b1, 16'h0090, 10'd100,  4'd7,  10'd100 }, // R7
      {1'b1, 16'h0010, 10'd101,  4'd4,  10'd22  }, // R5
      {1'b1, 16'h8000, 10'd23,   4'd15, 10'd31  }, // R5
      {1'b1, 16'h0080, 10'd32,   4'd7,  10'd101 }, // R5
      {1'b0, 16'h0000, 10'd1023, 4'd7,  10'd1023}  // R8
   };

   task automatic check(input string req, input logic [3:0] et, input logic [9:0] ea);
      n_tests++;
      if (cur_task !== et || fetch_addr !== ea) begin
         n_fail++;
         $display("FAIL %s: task=%0d addr=%0d expected task=%0d addr=%0d",
                  req, cur_task, fetch_addr, et, ea);
      end
   endtask

   task automatic step(input logic s, input logic [15:0] r, input logic [9:0] na);
      task_strobe = s; wake_req = r; next_addr = na;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 4'd0, 10'd0);
      rst_n = 1'b1;
      check("R1 after release", 4'd0, 10'd0);
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][40], VEC[i][39:24], VEC[i][23:14]);
         check($sformatf("vec %0d", i), VEC[i][13:10], VEC[i][9:0]);
      end
      // R1: reset mid-run reinitialises saved addresses
      rst_n = 1'b0;
      step(1'b0, 16'h0000, 10'd500);
      check("R1 mid-run reset", 4'd0, 10'd0);
      rst_n = 1'b1;
      step(1'b1, 16'h0084, 10'd9);
      check("R1 R4 slot7 reinit", 4'd7, 10'd7);
      step(1'b1, 16'h0004, 10'd11);
      check("R4 slot2 reinit", 4'd2, 10'd2);
      step(1'b1, 16'h0080, 10'd12);
      check("R5 slot7 saved", 4'd7, 10'd11);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule